// File: doc/BRIEF.md
# Microprogram Sequencer with Control Store

This block is the next-address engine of a microprogrammed control unit. It owns a 128-word by 20-bit control store, a 7-bit control address register (CAR) and a one-entry return register. Every clock it fetches the microinstruction at CAR and presents that word's three microoperation fields, which go to a datapath outside this block. It then chooses the next CAR from one of four sources: CAR plus one, the word's own address field, the saved return address, or a mapping of the macro-instruction opcode.

A 2-bit condition selector in each word picks the status bit that gates a branch. The choices are a constant true, the indirect-address bit, the accumulator sign, and accumulator-is-zero. The control store has no preset contents. It is filled through a write port before execution starts. While that port is active the sequencer holds still.

Microinstruction layout, most significant bit first: `[19:17]` field A, `[16:14]` field B, `[13:11]` field C, `[10:9]` condition select, `[8:7]` branch kind, `[6:0]` address. A microoperation code of 000 is a no-op.

Top module: `mseq_top`

## Requirements
- R1: While `rst_n` is low, CAR is set to 64, the fetch routine entry, and the return register is set to 0. CAR reads 64 on `car_trace` directly after reset.
- R2: `uop_a`, `uop_b` and `uop_c` equal bits [19:17], [16:14] and [13:11] of the stored word at the current CAR, in the same cycle that CAR takes that value.
- R3: The condition select field [10:9] picks the gating bit: 00 gives constant 1, 01 gives `ind_bit`, 10 gives `ac_sign`, 11 gives `ac_zero`.
- R4: Branch kind [8:7] = 00 is a conditional jump. If the condition is true, CAR loads the address field [6:0]. Otherwise CAR becomes CAR+1.
- R5: Branch kind 01 is a conditional call. If the condition is true, the return register loads CAR+1 and CAR loads the address field. Otherwise CAR becomes CAR+1 and the return register keeps its value.
- R6: Branch kind 10 is a return. CAR loads the return register whatever the condition evaluates to.
- R7: Branch kind 11 is an opcode map. CAR loads {0, opcode[3:0], 00}, giving four words per routine, whatever the condition evaluates to.
- R8: While `cm_wr_en` is high, the word `cm_wr_data` is written to `cm_wr_addr` on the clock edge, and CAR and the return register both hold. A word written at the current CAR shows on the microoperation outputs after that edge.
- R9: CAR+1 wraps modulo 128, so 127 is followed by 0.
- R10: `car_trace` always shows the current CAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cm_wr_en | input | 1 | Control store write enable; freezes sequencing |
| cm_wr_addr | input | 7 | Control store write address |
| cm_wr_data | input | 20 | Control store write word |
| opcode | input | 4 | Macro-instruction opcode for map branches |
| ind_bit | input | 1 | Indirect-address status bit |
| ac_sign | input | 1 | Accumulator sign status bit |
| ac_zero | input | 1 | Accumulator-zero status bit |
| uop_a | output | 3 | Microoperation field A of the current word |
| uop_b | output | 3 | Microoperation field B of the current word |
| uop_c | output | 3 | Microoperation field C of the current word |
| car_trace | output | 7 | Current control address |

## Verification
The bench targets the following corner cases, with the fault each one would expose:

- **Untaken call.** A design that loads the return register on every call, not only on a taken one, would return to the wrong place. The bench makes a call fail and then returns.
- **Return and map with a false condition.** A design that gates these branches on the condition would fall through to CAR+1 instead.
- **Increment at address 127.** This shows whether the wrap lands on 0. An adder that saturates, or one that is wider than 7 bits, would not.
- **Rewrite of the word under CAR.** The store is rewritten mid-run while a call is pending. This checks that writes freeze CAR and the return register but still change the visible fields.
- **Reset in the middle of a run.** A design that leaves the return register uncleared would be caught by a following return.

A long random walk over a randomly filled store covers the four condition sources against a bench model.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [1:0] {
        BR_JUMP = 2'b00,
        BR_CALL = 2'b01,
        BR_RET  = 2'b10,
        BR_MAP  = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        CS_ONE  = 2'b00,
        CS_IND  = 2'b01,
        CS_SIGN = 2'b10,
        CS_ZERO = 2'b11
    } cond_src_e;

endpackage

// File: rtl/mseq_cstore.sv
module mseq_cstore #(
    parameter int ADDR_W = 7,
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_addr];

endmodule

// File: rtl/mseq_cond_sel.sv
module mseq_cond_sel
    import mseq_pkg::*;
(
    input  cond_src_e sel,
    input  logic      ind_bit,
    input  logic      ac_sign,
    input  logic      ac_zero,
    output logic      cond
);
    always_comb begin
        unique case (sel)
            CS_ONE:  cond = 1'b1;
            CS_IND:  cond = ind_bit;
            CS_SIGN: cond = ac_sign;
            CS_ZERO: cond = ac_zero;
            default: cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/mseq_next_addr.sv
module mseq_next_addr
    import mseq_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int OPC_W    = 4,
    parameter int MAP_PAD  = 2,
    parameter int ENTRY    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              cond,
    input  br_kind_e          br,
    input  logic [ADDR_W-1:0] ad,
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] car
);
    typedef struct packed {
        logic [ADDR_W-1:0] car;
        logic [ADDR_W-1:0] sbr;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [ADDR_W-1:0] inc_d;
    logic [ADDR_W-1:0] map_d;

    always_comb begin
        st_d  = st_q;
        inc_d = st_q.car + ADDR_W'(1);
        map_d = ADDR_W'(opcode) << MAP_PAD;
        if (!hold) begin
            unique case (br)
                BR_JUMP: st_d.car = cond ? ad : inc_d;
                BR_CALL: begin
                    if (cond) begin
                        st_d.car = ad;
                        st_d.sbr = inc_d;
                    end else begin
                        st_d.car = inc_d;
                    end
                end
                BR_RET:  st_d.car = st_q.sbr;
                BR_MAP:  st_d.car = map_d;
                default: st_d     = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.car <= ADDR_W'(ENTRY);
            st_q.sbr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign car = st_q.car;

    a_r4_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && br == BR_JUMP && cond) |=> (st_q.car == $past(ad)));

    a_r4_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && (br == BR_JUMP || br == BR_CALL) && !cond)
        |=> (st_q.car == ADDR_W'($past(st_q.car) + 1)));

    a_r5_call_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && br == BR_CALL && cond)
        |=> (st_q.sbr == ADDR_W'($past(st_q.car) + 1) && st_q.car == $past(ad)));

    a_r5_untaken_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && br == BR_CALL && !cond) |=> $stable(st_q.sbr));

    a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && br == BR_RET) |=> (st_q.car == $past(st_q.sbr)));

    a_r7_map: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && br == BR_MAP)
        |=> (st_q.car == (ADDR_W'($past(opcode)) << MAP_PAD)));

    a_r8_write_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(st_q.car) && $stable(st_q.sbr)));

endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int OPC_W  = 4,
    parameter int UOP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cm_wr_en,
    input  logic [ADDR_W-1:0] cm_wr_addr,
    input  logic [3*UOP_W+4+ADDR_W-1:0] cm_wr_data,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              ind_bit,
    input  logic              ac_sign,
    input  logic              ac_zero,
    output logic [UOP_W-1:0]  uop_a,
    output logic [UOP_W-1:0]  uop_b,
    output logic [UOP_W-1:0]  uop_c,
    output logic [ADDR_W-1:0] car_trace
);
    localparam int WORD_W  = 3*UOP_W + 4 + ADDR_W;
    localparam int BR_LSB  = ADDR_W;
    localparam int CD_LSB  = ADDR_W + 2;
    localparam int UC_LSB  = ADDR_W + 4;
    localparam int UB_LSB  = UC_LSB + UOP_W;
    localparam int UA_LSB  = UB_LSB + UOP_W;
    localparam int ENTRY   = 1 << (ADDR_W - 1);
    localparam int MAP_PAD = ADDR_W - OPC_W - 1;

    logic [ADDR_W-1:0] car;
    logic [WORD_W-1:0] word;
    logic              cond;
    cond_src_e         cd_sel;
    br_kind_e          br_kind;

    mseq_cstore #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .wr_en   (cm_wr_en),
        .wr_addr (cm_wr_addr),
        .wr_data (cm_wr_data),
        .rd_addr (car),
        .rd_data (word)
    );

    assign cd_sel  = cond_src_e'(word[CD_LSB +: 2]);
    assign br_kind = br_kind_e'(word[BR_LSB +: 2]);

    mseq_cond_sel u_cond (
        .sel     (cd_sel),
        .ind_bit (ind_bit),
        .ac_sign (ac_sign),
        .ac_zero (ac_zero),
        .cond    (cond)
    );

    mseq_next_addr #(
        .ADDR_W  (ADDR_W),
        .OPC_W   (OPC_W),
        .MAP_PAD (MAP_PAD),
        .ENTRY   (ENTRY)
    ) u_next (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (cm_wr_en),
        .cond   (cond),
        .br     (br_kind),
        .ad     (word[ADDR_W-1:0]),
        .opcode (opcode),
        .car    (car)
    );

    assign uop_a     = word[UA_LSB +: UOP_W];
    assign uop_b     = word[UB_LSB +: UOP_W];
    assign uop_c     = word[UC_LSB +: UOP_W];
    assign car_trace = car;

    a_r3_const_true: assert property (@(posedge clk) disable iff (!rst_n)
        (!cm_wr_en && cd_sel == CS_ONE && br_kind == BR_JUMP)
        |=> (car_trace == $past(word[ADDR_W-1:0])));

endmodule

// File: tb/mseq_top_tb_top.sv
module mseq_top_tb_top;
    localparam int AW = 7;
    localparam int WW = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cm_wr_en;
    logic [AW-1:0] cm_wr_addr;
    logic [WW-1:0] cm_wr_data;
    logic [3:0]    opcode;
    logic          ind_bit, ac_sign, ac_zero;
    logic [2:0]    uop_a, uop_b, uop_c;
    logic [AW-1:0] car_trace;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [WW-1:0] ref_mem [128];
    logic [AW-1:0] ref_car;
    logic [AW-1:0] ref_sbr;

    always #5 clk = ~clk;

    mseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .cm_wr_en(cm_wr_en), .cm_wr_addr(cm_wr_addr),
        .cm_wr_data(cm_wr_data), .opcode(opcode), .ind_bit(ind_bit),
        .ac_sign(ac_sign), .ac_zero(ac_zero), .uop_a(uop_a), .uop_b(uop_b),
        .uop_c(uop_c), .car_trace(car_trace)
    );

    function automatic logic [WW-1:0] mk(input logic [1:0] cd, input logic [1:0] br,
                                         input logic [6:0] ad, input logic [8:0] uops);
        return {uops, cd, br, ad};
    endfunction

    function automatic logic pick_cond(input logic [1:0] cd, input logic i,
                                       input logic s, input logic z);
        case (cd)
            2'b00: return 1'b1;
            2'b01: return i;
            2'b10: return s;
            default: return z;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req);
        logic [WW-1:0] w;
        w = ref_mem[ref_car];
        chk({req, "/R10 car"}, 32'(car_trace), 32'(ref_car));
        chk("R2 uops", {23'd0, uop_a, uop_b, uop_c}, {23'd0, w[19:11]});
    endtask

    task automatic write_word(input logic [6:0] a, input logic [WW-1:0] d);
        cm_wr_en = 1'b1; cm_wr_addr = a; cm_wr_data = d;
        @(posedge clk); @(negedge clk);
        cm_wr_en = 1'b0;
        ref_mem[a] = d;
    endtask

    task automatic step(input logic [3:0] op, input logic i, input logic s, input logic z);
        logic [WW-1:0] w;
        logic c;
        logic [AW-1:0] inc;
        string tag;
        w = ref_mem[ref_car];
        c = pick_cond(w[10:9], i, s, z);
        inc = ref_car + 7'd1;
        opcode = op; ind_bit = i; ac_sign = s; ac_zero = z;
        case (w[8:7])
            2'b00: begin tag = c ? "R3/R4" : "R3/R4"; ref_car = c ? w[6:0] : inc; end
            2'b01: begin
                tag = "R3/R5";
                if (c) begin ref_sbr = inc; ref_car = w[6:0]; end
                else ref_car = inc;
            end
            2'b10: begin tag = "R6"; ref_car = ref_sbr; end
            default: begin tag = "R7"; ref_car = {1'b0, op, 2'b00}; end
        endcase
        if (inc == 7'd0 && ref_car == 7'd0) tag = {tag, "/R9"};
        @(posedge clk); @(negedge clk);
        chk_outputs(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        ref_car = 7'd64;
        ref_sbr = 7'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; cm_wr_en = 1'b1; cm_wr_addr = '0; cm_wr_data = '0;
        opcode = '0; ind_bit = 0; ac_sign = 0; ac_zero = 0;
        @(negedge clk);
        do_reset();
        chk("R1 entry", 32'(car_trace), 32'd64);

        // R8: fill the store; CAR must stay at the entry while writing
        for (int k = 0; k < 128; k++) begin
            cm_wr_en = 1'b1; cm_wr_addr = 7'(k); cm_wr_data = WW'($urandom);
            ref_mem[k] = cm_wr_data;
            @(posedge clk); @(negedge clk);
        end
        cm_wr_en = 1'b0;
        chk("R8 hold during fill", 32'(car_trace), 32'd64);
        chk_outputs("R1");

        // random walk over a random store
        for (int n = 0; n < 3000; n++) begin
            step(4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // directed corner cases
        do_reset();
        chk("R1 mid-run reset", 32'(car_trace), 32'd64);
        write_word(7'd64,  mk(2'b00, 2'b00, 7'd127, 9'o123));
        write_word(7'd127, mk(2'b01, 2'b00, 7'd10,  9'o456));
        write_word(7'd0,   mk(2'b11, 2'b01, 7'd20,  9'o701));
        write_word(7'd1,   mk(2'b10, 2'b01, 7'd30,  9'o012));
        write_word(7'd30,  mk(2'b01, 2'b10, 7'd99,  9'o345));
        write_word(7'd2,   mk(2'b01, 2'b11, 7'd99,  9'o567));
        chk("R8 hold after writes", 32'(car_trace), 32'd64);
        chk_outputs("R8");
        step(4'h0, 1'b0, 1'b0, 1'b0);   // R4 constant-true jump to 127
        step(4'h0, 1'b0, 1'b0, 1'b0);   // R9 false jump wraps 127 -> 0
        step(4'h0, 1'b0, 1'b0, 1'b0);   // R5 untaken call on zero=0 -> 1
        step(4'h0, 1'b0, 1'b1, 1'b0);   // R5 taken call on sign, sbr=2
        // R8 rewrite word under CAR while call pending
        write_word(7'd30, mk(2'b01, 2'b10, 7'd99, 9'o777));
        chk("R8 car frozen", 32'(car_trace), 32'd30);
        chk_outputs("R8");
        step(4'h0, 1'b0, 1'b0, 1'b0);   // R6 return with false condition -> 2
        step(4'hB, 1'b0, 1'b0, 1'b0);   // R7 map with false condition -> 44
        chk("R7 map address", 32'(car_trace), 32'd44);

        // R5: untaken call must not disturb the return register
        do_reset();
        write_word(7'd64, mk(2'b01, 2'b01, 7'd50, 9'o111));
        write_word(7'd65, mk(2'b01, 2'b10, 7'd0,  9'o222));
        step(4'h0, 1'b0, 1'b0, 1'b0);   // untaken call -> 65
        step(4'h0, 1'b0, 1'b0, 1'b0);   // return -> sbr (0 after reset, R1)
        chk("R5/R1 sbr untouched", 32'(car_trace), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule